// File: doc/BRIEF.md
# NAND Flash Strobe Timing Sequencer

This block turns single-byte bus requests into correctly timed cycles on an 8-bit asynchronous memory bus that has NAND flash on it. A 32-bit timing word gives the setup, strobe and hold lengths for reads and for writes, and the idle gap that follows each access. The requester gives a direction, a cycle type (data, command or address) and a flag that selects the secondary chip. The sequencer then runs chip select, the active-low write and read strobes, and the address bus. Command and address cycles are marked by raising two fixed address lines. They are not marked by dedicated pins.

Each access has four phases: setup, strobe, hold and turnaround. A phase lasts its field value plus one clock. A read captures the bus byte on the final strobe cycle, and a one-cycle done pulse follows the hold phase. The shared wired-AND ready/busy line from the flash devices is synchronized and returned as a ready flag.

Top module: `nand_strobe_seq`

## Requirements
- R1: Timing fields of `cfg_word`: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4]. Each phase lasts field value + 1 clocks, using the fields of the request's direction.
- R2: `nand_cs_n` is low through setup, strobe and hold. `nand_we_n` is low only in the strobe phase of a write, and `nand_oe_n` is low only in the strobe phase of a read. The unused strobe stays high.
- R3: A read captures `nand_din` at the clock edge that ends the last strobe cycle. `rd_data` holds that byte until the next read capture.
- R4: `done` is high for exactly one cycle: the first cycle after the hold phase, when `nand_cs_n` has just returned high.
- R5: The turnaround field [3:2] adds field + 1 cycles after hold, during which `req_ready` is low. With `req_valid` held high, the bus shows turnaround + 2 chip-select-high cycles between two accesses.
- R6: `nand_addr` is BASE_ADDR, ORed with CS2_MASK when `req_chip` is 1. `req_kind` 1 (command) also sets address bit 4. `req_kind` 2 (address) also sets bit 3. Kinds 0 and 3 are data cycles and set neither bit. The address stays steady for the whole access.
- R7: If bit 31 or bit 30 of `cfg_word` is set, or bits [1:0] are nonzero, `req_ready` is low and no access starts.
- R8: Timing fields are captured when a request is accepted. Changing `cfg_word` during an access does not alter that access.
- R9: `flash_ready` follows `nand_rdy` through a SYNC_STAGES-flop synchronizer (2 by default). It resets to 0.
- R10: During setup, strobe and hold of a write, `nand_dout_en` is 1 and `nand_dout` carries the request byte. `nand_dout_en` is 0 at all other times.
- R11: In and right after reset, chip select and both strobes are high, `done` and `nand_dout_en` are 0, and `req_ready` is 1 when the timing word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing and mode word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_chip | input | 1 | Select the secondary chip |
| req_wdata | input | DATA_W | Byte to write |
| done | output | 1 | One-cycle access-complete pulse |
| rd_data | output | DATA_W | Last byte read |
| flash_ready | output | 1 | Synchronized ready/busy status |
| nand_cs_n | output | 1 | Chip select, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_oe_n | output | 1 | Read strobe, active low |
| nand_addr | output | ADDR_W | Byte address bus |
| nand_dout | output | DATA_W | Data toward the flash |
| nand_dout_en | output | 1 | Data driver enable |
| nand_din | input | DATA_W | Data from the flash |
| nand_rdy | input | 1 | Wired-AND ready/busy line |

## Verification
The bench sweeps every small setup, strobe, hold and turnaround combination for both directions. The other direction's fields are set to distinct values, so a design that read the wrong field or dropped the +1 would show wrong phase lengths. Read data changes on every strobe cycle, so capturing one cycle early or late returns the wrong byte. A timing word changed in the middle of an access catches a design that does not snapshot its fields. Back-to-back requests with `req_valid` held high expose an accept that skips the turnaround gap. Invalid mode bits must block the bus entirely, and the ready synchronizer is checked for its exact two-edge latency.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int CNT_W = 6;

  localparam int WR_SETUP_LSB  = 26;
  localparam int WR_SETUP_W    = 4;
  localparam int WR_STROBE_LSB = 20;
  localparam int WR_STROBE_W   = 6;
  localparam int WR_HOLD_LSB   = 17;
  localparam int WR_HOLD_W     = 3;
  localparam int RD_SETUP_LSB  = 13;
  localparam int RD_SETUP_W    = 4;
  localparam int RD_STROBE_LSB = 7;
  localparam int RD_STROBE_W   = 6;
  localparam int RD_HOLD_LSB   = 4;
  localparam int RD_HOLD_W     = 3;
  localparam int TURN_LSB      = 2;
  localparam int TURN_W        = 2;
  localparam int WIDTH_LSB     = 0;
  localparam int WIDTH_W       = 2;
  localparam int EXTWAIT_BIT   = 30;
  localparam int STRMODE_BIT   = 31;

  localparam int CLE_BIT = 4;
  localparam int ALE_BIT = 3;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_DAT2 = 2'd3
  } kind_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
  } dir_timing_t;

  typedef struct packed {
    dir_timing_t      wr;
    dir_timing_t      rd;
    logic [CNT_W-1:0] turn;
  } bus_timing_t;

endpackage

// File: rtl/nand_cfg_decode.sv
module nand_cfg_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0] cfg_word,
  output bus_timing_t timing,
  output logic        cfg_ok
);

  assign timing.wr.setup  = CNT_W'(cfg_word[WR_SETUP_LSB  +: WR_SETUP_W]);
  assign timing.wr.strobe = CNT_W'(cfg_word[WR_STROBE_LSB +: WR_STROBE_W]);
  assign timing.wr.hold   = CNT_W'(cfg_word[WR_HOLD_LSB   +: WR_HOLD_W]);
  assign timing.rd.setup  = CNT_W'(cfg_word[RD_SETUP_LSB  +: RD_SETUP_W]);
  assign timing.rd.strobe = CNT_W'(cfg_word[RD_STROBE_LSB +: RD_STROBE_W]);
  assign timing.rd.hold   = CNT_W'(cfg_word[RD_HOLD_LSB   +: RD_HOLD_W]);
  assign timing.turn      = CNT_W'(cfg_word[TURN_LSB      +: TURN_W]);

  // NAND operation needs plain strobe mode, no extended wait, 8-bit width
  assign cfg_ok = !cfg_word[STRMODE_BIT] && !cfg_word[EXTWAIT_BIT] &&
                  (cfg_word[WIDTH_LSB +: WIDTH_W] == '0);

endmodule

// File: rtl/nand_phase_ctrl.sv
module nand_phase_ctrl
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  input  bus_timing_t timing,
  output phase_e      phase_o,
  output phase_e      phase_next_o,
  output logic        wr_o,
  output logic        wr_next_o,
  output logic        last_o
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] strobe_q, hold_q, turn_q;
  logic             wr_q, wr_d;
  logic             snap_en, cnt_en, last;
  dir_timing_t      sel;

  assign sel     = start_wr ? timing.wr : timing.rd;
  assign last    = (cnt_q == '0);
  assign snap_en = (phase_q == PH_IDLE) && start;
  assign cnt_en  = (phase_q != PH_IDLE) || start;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = sel.setup;
          wr_d    = start_wr;
        end
      end
      PH_SETUP: begin
        if (last) begin
          phase_d = PH_STROBE;
          cnt_d   = strobe_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (last) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_TURN;
          cnt_d   = turn_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_TURN: begin
        if (last) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      hold_q   <= '0;
      turn_q   <= '0;
    end else if (snap_en) begin
      strobe_q <= sel.strobe;
      hold_q   <= sel.hold;
      turn_q   <= timing.turn;
    end
  end

  assign phase_o      = phase_q;
  assign phase_next_o = phase_d;
  assign wr_o         = wr_q;
  assign wr_next_o    = wr_d;
  assign last_o       = last;

endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import nand_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [ADDR_W-1:0] CS2_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  kind_e             kind,
  input  logic              chip,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout
);

  localparam logic [ADDR_W-1:0] CLE_MASK = ADDR_W'(1) << CLE_BIT;
  localparam logic [ADDR_W-1:0] ALE_MASK = ADDR_W'(1) << ALE_BIT;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    addr_d = BASE_ADDR;
    if (chip) addr_d = addr_d | CS2_MASK;
    case (kind)
      KIND_CMD:  addr_d = addr_d | CLE_MASK;
      KIND_ADDR: addr_d = addr_d | ALE_MASK;
      default:   addr_d = addr_d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= BASE_ADDR;
      dout_q <= '0;
    end else if (load) begin
      addr_q <= addr_d;
      dout_q <= wdata;
    end
  end

  assign addr = addr_q;
  assign dout = dout_q;

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h2000,
  parameter logic [ADDR_W-1:0] CS2_MASK    = 16'h4000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic              req_chip,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              flash_ready,
  output logic              nand_cs_n,
  output logic              nand_we_n,
  output logic              nand_oe_n,
  output logic [ADDR_W-1:0] nand_addr,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_dout_en,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rdy
);

  bus_timing_t timing;
  logic        cfg_ok;
  phase_e      phase_q, phase_d;
  logic        wr_q, wr_d, last;
  logic        accept;
  logic        busy_d, strobe_d;
  logic        cs_n_q, we_n_q, oe_n_q, dout_en_q, done_q;
  logic        cap_en;
  logic [DATA_W-1:0] rd_q;

  assign req_ready = (phase_q == PH_IDLE) && cfg_ok;
  assign accept    = req_valid && req_ready;

  nand_cfg_decode u_cfg (
    .cfg_word (cfg_word),
    .timing   (timing),
    .cfg_ok   (cfg_ok)
  );

  nand_phase_ctrl u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .start_wr     (req_write),
    .timing       (timing),
    .phase_o      (phase_q),
    .phase_next_o (phase_d),
    .wr_o         (wr_q),
    .wr_next_o    (wr_d),
    .last_o       (last)
  );

  nand_addr_gen #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .CS2_MASK  (CS2_MASK)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .kind  (kind_e'(req_kind)),
    .chip  (req_chip),
    .wdata (req_wdata),
    .addr  (nand_addr),
    .dout  (nand_dout)
  );

  // Bus controls are flops fed from the next phase: no decode glitches
  assign busy_d   = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                    (phase_d == PH_HOLD);
  assign strobe_d = (phase_d == PH_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dout_en_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      cs_n_q    <= !busy_d;
      we_n_q    <= !(strobe_d && wr_d);
      oe_n_q    <= !(strobe_d && !wr_d);
      dout_en_q <= busy_d && wr_d;
      done_q    <= (phase_q == PH_HOLD) && last;
    end
  end

  assign cap_en = (phase_q == PH_STROBE) && last && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= nand_din;
    end
  end

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= nand_rdy;
      end
      assign flash_ready = sync_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], nand_rdy};
      end
      assign flash_ready = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  assign nand_cs_n    = cs_n_q;
  assign nand_we_n    = we_n_q;
  assign nand_oe_n    = oe_n_q;
  assign nand_dout_en = dout_en_q;
  assign done         = done_q;
  assign rd_data      = rd_q;

endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_word,
  input logic              req_ready,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              done,
  input logic              dout_en,
  input logic [ADDR_W-1:0] addr
);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !cs_n);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));

  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));

  p_cfg_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_word[31:30] != 2'b00) || (cfg_word[1:0] != 2'b00)) |-> !req_ready);

  p_dout_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !cs_n);

endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_word  (cfg_word),
  .req_ready (req_ready),
  .cs_n      (nand_cs_n),
  .we_n      (nand_we_n),
  .oe_n      (nand_oe_n),
  .done      (done),
  .dout_en   (nand_dout_en),
  .addr      (nand_addr)
);

// File: tb/nand_strobe_seq_tb_top.sv
module nand_strobe_seq_tb_top;

  localparam int          ADDR_W = 16;
  localparam int          DATA_W = 8;
  localparam logic [15:0] BASE   = 16'h2000;
  localparam logic [15:0] CS2    = 16'h4000;

  logic              clk;
  logic              rst_n;
  logic [31:0]       cfg_word;
  logic              req_valid, req_ready, req_write, req_chip;
  logic [1:0]        req_kind;
  logic [DATA_W-1:0] req_wdata, rd_data, nand_dout, nand_din;
  logic              done, flash_ready, nand_cs_n, nand_we_n, nand_oe_n;
  logic              nand_dout_en, nand_rdy;
  logic [ADDR_W-1:0] nand_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] din_ctr = 8'h00;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  nand_strobe_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE), .CS2_MASK(CS2), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_kind(req_kind), .req_chip(req_chip), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .flash_ready(flash_ready),
    .nand_cs_n(nand_cs_n), .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n),
    .nand_addr(nand_addr), .nand_dout(nand_dout), .nand_dout_en(nand_dout_en),
    .nand_din(nand_din), .nand_rdy(nand_rdy)
  );

  function automatic logic [31:0] mk_cfg(int ws, int wt, int wh, int rs, int rt, int rh, int ta);
    return (32'(ws) << 26) | (32'(wt) << 20) | (32'(wh) << 17) |
           (32'(rs) << 13) | (32'(rt) << 7)  | (32'(rh) << 4)  | (32'(ta) << 2);
  endfunction

  function automatic logic [15:0] exp_addr(logic [1:0] kind, bit chip);
    logic [15:0] a;
    a = BASE;
    if (chip) a = a | CS2;
    if (kind == 2'd1) a = a | 16'h0010;
    if (kind == 2'd2) a = a | 16'h0008;
    return a;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!req_ready && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic run_access(input bit wr, input logic [1:0] kind, input bit chip,
                            input logic [7:0] wd, input int es, input int et,
                            input int eh, input int eg, input bit swap,
                            input logic [31:0] swap_val, input string rq);
    int ns = 0, nt = 0, nh = 0, ng = 0, nd = 0, guard = 0;
    bit seen = 0, aok = 1, dok = 1, xok = 1;
    logic [7:0]  last_din = 8'h00;
    logic [15:0] ea;
    ea = exp_addr(kind, chip);
    wait_idle();
    req_write = wr; req_kind = kind; req_chip = chip; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (nand_cs_n == 1'b0 && guard < 3000) begin
      if (swap && guard == 0) cfg_word = swap_val;
      if (nand_addr !== ea) aok = 0;
      if (wr && (nand_dout_en !== 1'b1 || nand_dout !== wd)) dok = 0;
      if (!wr && nand_dout_en !== 1'b0) dok = 0;
      if (wr ? (nand_oe_n !== 1'b1) : (nand_we_n !== 1'b1)) xok = 0;
      if ((wr ? nand_we_n : nand_oe_n) == 1'b0) begin
        nt++;
        seen = 1;
        if (!wr) begin
          din_ctr  = din_ctr + 8'd37;
          nand_din = din_ctr;
          last_din = din_ctr;
        end
      end else if (!seen) ns++;
      else nh++;
      if (done) nd++;
      guard++;
      @(negedge clk);
    end
    // R4: pulse must be present in the first cycle with chip select released
    chk(done == 1'b1, "R4", "done in first cycle after hold", int'(done), 1);
    while (!req_ready && guard < 6000) begin
      ng++;
      if (done) nd++;
      guard++;
      @(negedge clk);
    end
    chk(ns == es, rq, "setup cycles", ns, es);
    chk(nt == et, rq, "strobe cycles", nt, et);
    chk(nh == eh, rq, "hold cycles", nh, eh);
    chk(ng == eg, (rq == "R8") ? "R8" : "R5", "turnaround cycles", ng, eg);
    chk(nd == 1, "R4", "done pulse count", nd, 1);
    chk(aok, "R6", "address during access", int'(nand_addr), int'(ea));
    chk(dok, "R10", "write data drive", int'(nand_dout), int'(wd));
    chk(xok, "R2", "opposite strobe stays high", 0, 1);
    if (!wr) chk(rd_data == last_din, "R3", "read capture", int'(rd_data), int'(last_din));
  endtask

  // watchdog
  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int idx;
    int gap, g;
    bit ok;
    logic [31:0] bad [3];
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_kind = 2'd0;
    req_chip = 1'b0; req_wdata = 8'h00; nand_din = 8'h00; nand_rdy = 1'b0;
    cfg_word = mk_cfg(1, 2, 1, 1, 2, 1, 1);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(nand_cs_n && nand_we_n && nand_oe_n, "R11", "strobes high in reset", 0, 1);
    chk(!done && !nand_dout_en, "R11", "done/dout_en low in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
    chk(nand_cs_n && !done && !nand_dout_en, "R11", "idle bus after reset", int'(nand_cs_n), 1);
    chk(flash_ready == 1'b0, "R9", "flash_ready reset value", int'(flash_ready), 0);

    // R1 sweep: both directions, other direction's fields set to distinct values
    idx = 0;
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 3; t++)
          for (int h = 0; h < 3; h++)
            for (int ta = 0; ta < 4; ta++) begin
              if (d == 1) cfg_word = mk_cfg(s, t, h, 9, 17, 5, ta);
              else        cfg_word = mk_cfg(11, 21, 6, s, t, h, ta);
              run_access(d == 1, 2'(idx), ((idx / 4) % 2) == 1, 8'(idx * 7 + 3),
                         s + 1, t + 1, h + 1, ta + 1, 1'b0, 32'h0, "R1");
              idx++;
            end

    // R1 largest field values
    cfg_word = mk_cfg(15, 63, 7, 0, 0, 0, 3);
    run_access(1'b1, 2'd1, 1'b1, 8'hA5, 16, 64, 8, 4, 1'b0, 32'h0, "R1");
    cfg_word = mk_cfg(0, 0, 0, 15, 63, 7, 3);
    run_access(1'b0, 2'd2, 1'b0, 8'h00, 16, 64, 8, 4, 1'b0, 32'h0, "R1");

    // R8 config change in the middle of an access
    cfg_word = mk_cfg(0, 0, 0, 2, 3, 2, 2);
    run_access(1'b0, 2'd0, 1'b0, 8'h00, 3, 4, 3, 3, 1'b1, mk_cfg(0, 0, 0, 0, 0, 0, 0), "R8");
    run_access(1'b0, 2'd0, 1'b0, 8'h00, 1, 1, 1, 1, 1'b0, 32'h0, "R8");

    // R5 back-to-back with req_valid held
    cfg_word = mk_cfg(0, 0, 0, 0, 0, 0, 2);
    wait_idle();
    req_write = 1'b0; req_kind = 2'd0; req_chip = 1'b0; req_valid = 1'b1;
    g = 0;
    while (nand_cs_n == 1'b1 && g < 100) begin @(negedge clk); g++; end
    while (nand_cs_n == 1'b0 && g < 200) begin @(negedge clk); g++; end
    gap = 0;
    while (nand_cs_n == 1'b1 && g < 300) begin gap++; @(negedge clk); g++; end
    req_valid = 1'b0;
    chk(gap == 4, "R5", "cs high gap between held requests", gap, 4);
    wait_idle();

    // R7 invalid mode bits block the bus
    bad[0] = mk_cfg(1, 1, 1, 1, 1, 1, 1) | 32'h4000_0000;
    bad[1] = mk_cfg(1, 1, 1, 1, 1, 1, 1) | 32'h8000_0000;
    bad[2] = mk_cfg(1, 1, 1, 1, 1, 1, 1) | 32'h0000_0001;
    for (int b = 0; b < 3; b++) begin
      cfg_word = bad[b];
      req_valid = 1'b1;
      ok = 1;
      repeat (6) begin
        @(negedge clk);
        if (nand_cs_n !== 1'b1 || req_ready !== 1'b0) ok = 0;
      end
      req_valid = 1'b0;
      chk(ok, "R7", "invalid config blocks access", int'(req_ready), 0);
      cfg_word = mk_cfg(1, 1, 1, 1, 1, 1, 1);
      @(negedge clk);
    end

    // R9 synchronizer latency
    nand_rdy = 1'b1;
    @(negedge clk);
    chk(flash_ready == 1'b0, "R9", "ready after one edge", int'(flash_ready), 0);
    @(negedge clk);
    chk(flash_ready == 1'b1, "R9", "ready after two edges", int'(flash_ready), 1);
    nand_rdy = 1'b0;
    @(negedge clk);
    chk(flash_ready == 1'b1, "R9", "busy after one edge", int'(flash_ready), 1);
    @(negedge clk);
    chk(flash_ready == 1'b0, "R9", "busy after two edges", int'(flash_ready), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule